// File: doc/BRIEF.md
# Shared I/O Pin Combiner for Eight Cores

This block lets eight processor cores drive one common bank of 32 I/O pins at the same time, with no arbiter between them. Each core keeps a private 32-bit direction register and a private 32-bit output register, loaded through a per-core register write port. Each core also supplies two auxiliary output vectors, which stand for its timer-counter and video outputs.

A core's contribution to the pins is the OR of its output register and its auxiliary vectors, masked by that core's own direction bits. The pin direction vector is the OR of every active core's direction register. The pin output vector is the OR of every active core's masked contribution.

When a core's active flag drops, its influence on the pins is removed at once, and its registers are cleared at the next clock edge. Pad levels come back through a two-flop synchronizer. Every core sees the same result as its read-only input register, whatever the pin directions are.

Top module: `pin_share_combiner`

## Requirements
- R1: While rst_ni is low, all direction and output registers are zero, so pin_dir_o and pin_out_o are zero (every pin an input) and every slice of core_in_o is zero.
- R2: A write is taken at the clock edge where wr_en_i[c] is 1 and core c is active. wr_sel_i[c]=0 loads the direction register of core c and wr_sel_i[c]=1 loads its output register, each from slice c of wr_data_i (bits c*32+31 down to c*32). The new value shows at the pins after that edge.
- R3: pin_dir_o is the bitwise OR of the direction registers of all active cores. A bit value of 1 means output and 0 means input.
- R4: The output register bits and auxiliary bits of a core reach the pins only where that core's own direction bit is 1.
- R5: pin_out_o is the bitwise OR of all active cores' masked contributions. A pin is high if any active core drives it as an output and high. It is low only if every active core driving it as an output drives it low.
- R6: A core whose core_active_i bit is 0 contributes nothing to pin_dir_o or pin_out_o in that same cycle. Both of its registers are cleared at the next edge, so a core that becomes active again starts with zero registers.
- R7: If a write and a shutdown reach the same core in the same cycle, the shutdown wins: the write is dropped and the registers are cleared.
- R8: Every slice of core_in_o equals pin_level_i as sampled two clock edges earlier, with the same value for all cores, whatever the pin directions are.
- R9: pin_out_o is never 1 on a pin whose pin_dir_o bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_active_i | input | 8 | Per-core active flag; 0 shuts the core down |
| wr_en_i | input | 8 | Per-core register write enable |
| wr_sel_i | input | 8 | Per-core register select: 0 for direction, 1 for output |
| wr_data_i | input | 256 | Per-core write data, 32 bits per core |
| aux_a_i | input | 256 | Per-core counter output vectors |
| aux_b_i | input | 256 | Per-core video output vectors |
| pin_level_i | input | 32 | Live pad levels |
| pin_dir_o | output | 32 | Combined pin direction, 1 means output |
| pin_out_o | output | 32 | Combined pin output level |
| core_in_o | output | 256 | Synchronized pin levels, one 32-bit copy per core |

## Verification
The bench drives pin 12 through the classic sharing cases: no driver, one core driving low, one core driving high, and several cores driving with mixed levels. A design that ORed raw output registers without the direction mask would drive a pin high from a core that only holds an output bit and never claimed the pin.

Auxiliary vectors are driven on pins whose direction bit is 0. A design that masked only the output register would leak counter or video bits onto those pins.

Shutdown is exercised in the same cycle as a write, and a core is brought back after one inactive cycle. A design that let the write win, or that only gated the core combinationally without clearing it, would bring stale values back to the pins.

Random phases compare every cycle against a behavioural model. This includes the input path, where a synchronizer one flop short or one flop long shows up as a one-cycle shift.

// File: rtl/pin_share_pkg.sv
package pin_share_pkg;
  typedef enum logic {
    SEL_DIR = 1'b0,
    SEL_OUT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/core_pin_regs.sv
module core_pin_regs
  import pin_share_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                active_i,
  input  logic                wr_en_i,
  input  logic                wr_sel_i,
  input  logic [NUM_PINS-1:0] wr_data_i,
  input  logic [NUM_PINS-1:0] aux_a_i,
  input  logic [NUM_PINS-1:0] aux_b_i,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] drive_o
);
  logic [NUM_PINS-1:0] dir_q, out_q;
  reg_sel_e sel;

  assign sel = reg_sel_e'(wr_sel_i);

  // shutdown clears and overrides any write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (!active_i) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (wr_en_i) begin
      if (sel == SEL_DIR) dir_q <= wr_data_i;
      else                out_q <= wr_data_i;
    end
  end

  // removal is immediate, not delayed by the clearing edge
  always_comb begin
    dir_o   = active_i ? dir_q : '0;
    drive_o = active_i ? ((out_q | aux_a_i | aux_b_i) & dir_q) : '0;
  end
endmodule

// File: rtl/wide_or.sv
module wide_or #(
  parameter int NUM_IN = 8,
  parameter int WIDTH  = 32
) (
  input  logic [NUM_IN*WIDTH-1:0] in_i,
  output logic [WIDTH-1:0]        out_o
);
  always_comb begin
    out_o = '0;
    for (int i = 0; i < NUM_IN; i++) out_o |= in_i[i*WIDTH +: WIDTH];
  end
endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pin_share_combiner.sv
module pin_share_combiner #(
  parameter int NUM_CORES   = 8,
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_CORES-1:0]          core_active_i,
  input  logic [NUM_CORES-1:0]          wr_en_i,
  input  logic [NUM_CORES-1:0]          wr_sel_i,
  input  logic [NUM_CORES*NUM_PINS-1:0] wr_data_i,
  input  logic [NUM_CORES*NUM_PINS-1:0] aux_a_i,
  input  logic [NUM_CORES*NUM_PINS-1:0] aux_b_i,
  input  logic [NUM_PINS-1:0]           pin_level_i,
  output logic [NUM_PINS-1:0]           pin_dir_o,
  output logic [NUM_PINS-1:0]           pin_out_o,
  output logic [NUM_CORES*NUM_PINS-1:0] core_in_o
);
  localparam int FLAT_W = NUM_CORES * NUM_PINS;

  logic [FLAT_W-1:0]   dir_flat, drive_flat;
  logic [NUM_PINS-1:0] level_sync;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    core_pin_regs #(.NUM_PINS(NUM_PINS)) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .active_i  (core_active_i[c]),
      .wr_en_i   (wr_en_i[c]),
      .wr_sel_i  (wr_sel_i[c]),
      .wr_data_i (wr_data_i[c*NUM_PINS +: NUM_PINS]),
      .aux_a_i   (aux_a_i[c*NUM_PINS +: NUM_PINS]),
      .aux_b_i   (aux_b_i[c*NUM_PINS +: NUM_PINS]),
      .dir_o     (dir_flat[c*NUM_PINS +: NUM_PINS]),
      .drive_o   (drive_flat[c*NUM_PINS +: NUM_PINS])
    );
    assign core_in_o[c*NUM_PINS +: NUM_PINS] = level_sync;
  end

  wide_or #(.NUM_IN(NUM_CORES), .WIDTH(NUM_PINS)) u_dir_or (
    .in_i  (dir_flat),
    .out_o (pin_dir_o)
  );

  wide_or #(.NUM_IN(NUM_CORES), .WIDTH(NUM_PINS)) u_out_or (
    .in_i  (drive_flat),
    .out_o (pin_out_o)
  );

  pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_level_i),
    .q_o    (level_sync)
  );
endmodule

// File: rtl/pin_share_checker.sv
module pin_share_checker #(
  parameter int NUM_CORES = 8,
  parameter int NUM_PINS  = 32
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_CORES-1:0]          core_active_i,
  input logic [NUM_CORES-1:0]          wr_en_i,
  input logic [NUM_CORES-1:0]          wr_sel_i,
  input logic [NUM_CORES*NUM_PINS-1:0] wr_data_i,
  input logic [NUM_CORES*NUM_PINS-1:0] aux_a_i,
  input logic [NUM_CORES*NUM_PINS-1:0] aux_b_i,
  input logic [NUM_PINS-1:0]           pin_level_i,
  input logic [NUM_PINS-1:0]           pin_dir_o,
  input logic [NUM_PINS-1:0]           pin_out_o,
  input logic [NUM_CORES*NUM_PINS-1:0] core_in_o
);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             since_rst <= '0;
    else if (since_rst != 2) since_rst <= since_rst + 2'd1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (pin_dir_o == '0 && pin_out_o == '0 && core_in_o == '0)
        else $error("pins not idle in reset");
    end
  end

  assert_out_needs_dir_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_out_o & ~pin_dir_o) == '0);

  assert_all_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_active_i == '0) |-> (pin_dir_o == '0 && pin_out_o == '0));

  // aux bits are ORed into the output only through the direction mask
  assert_aux_masked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((aux_a_i | aux_b_i) != '0 && pin_dir_o == '0) |-> (pin_out_o == '0));

  assert_sync_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2) |-> (core_in_o[NUM_PINS-1:0] == $past(pin_level_i, 2)));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    assert_dir_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i[c] && !wr_sel_i[c] && core_active_i[c]) |=>
      (!core_active_i[c] ||
       ((pin_dir_o & $past(wr_data_i[c*NUM_PINS +: NUM_PINS])) ==
        $past(wr_data_i[c*NUM_PINS +: NUM_PINS]))));

    assert_same_view_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      core_in_o[c*NUM_PINS +: NUM_PINS] == core_in_o[NUM_PINS-1:0]);
  end
endmodule

bind pin_share_combiner pin_share_checker #(
  .NUM_CORES (NUM_CORES),
  .NUM_PINS  (NUM_PINS)
) u_chk (.*);

// File: tb/pin_share_combiner_bench.sv
`timescale 1ns/1ps
module pin_share_combiner_bench;
  localparam int NC = 8;
  localparam int NP = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NC-1:0] active, wr_en, wr_sel;
  logic [NC*NP-1:0] wr_data, aux_a, aux_b, core_in;
  logic [NP-1:0] level, pin_dir, pin_out;

  always #2 clk = ~clk;

  pin_share_combiner u_pin_share_combiner (
    .clk_i(clk), .rst_ni(rst_ni), .core_active_i(active), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .aux_a_i(aux_a), .aux_b_i(aux_b),
    .pin_level_i(level), .pin_dir_o(pin_dir), .pin_out_o(pin_out), .core_in_o(core_in)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model
  logic [NP-1:0] m_dir [NC];
  logic [NP-1:0] m_out [NC];
  logic [NP-1:0] lvl_q [$];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NC; c++) begin m_dir[c] <= '0; m_out[c] <= '0; end
      lvl_q.delete();
    end else begin
      for (int c = 0; c < NC; c++) begin
        if (!active[c]) begin m_dir[c] <= '0; m_out[c] <= '0; end
        else if (wr_en[c]) begin
          if (wr_sel[c]) m_out[c] <= wr_data[c*NP +: NP];
          else           m_dir[c] <= wr_data[c*NP +: NP];
        end
      end
      lvl_q.push_back(level);
      if (lvl_q.size() > 2) void'(lvl_q.pop_front());
    end
  end

  task automatic check(string req, logic [NP-1:0] act, logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // compare on every cycle, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_ni && !done) begin
      logic [NP-1:0] e_dir, e_out, e_in;
      e_dir = '0; e_out = '0;
      for (int c = 0; c < NC; c++) if (active[c]) begin
        e_dir |= m_dir[c];
        e_out |= (m_out[c] | aux_a[c*NP +: NP] | aux_b[c*NP +: NP]) & m_dir[c];
      end
      e_in = (lvl_q.size() == 2) ? lvl_q[0] : '0;
      check("R3 dir", pin_dir, e_dir);
      check("R5 out", pin_out, e_out);
      for (int c = 0; c < NC; c++) check("R8 in", core_in[c*NP +: NP], e_in);
    end
  end

  task automatic idle_inputs();
    wr_en = '0; wr_sel = '0; wr_data = '0; aux_a = '0; aux_b = '0;
  endtask

  // load bit 12 of every core, then check pin 12
  task automatic pin12_case(logic [NC-1:0] d, logic [NC-1:0] o, string req);
    @(negedge clk);
    wr_en = '1; wr_sel = '0;
    for (int c = 0; c < NC; c++) wr_data[c*NP +: NP] = 32'(d[c]) << 12;
    @(negedge clk);
    wr_sel = '1;
    for (int c = 0; c < NC; c++) wr_data[c*NP +: NP] = 32'(o[c]) << 12;
    @(negedge clk);
    idle_inputs();
    check({req, " pin12 dir"}, 32'(pin_dir[12]), 32'(|d));
    check({req, " pin12 out"}, 32'(pin_out[12]), 32'(|(d & o)));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    active = '1; level = '0; idle_inputs();
    level = 32'hA5A5_0F0F;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 dir", pin_dir, '0);
    check("R1 out", pin_out, '0);
    check("R1 in", core_in[NP-1:0], '0);
    rst_ni = 1'b1;

    // R3 R5: sharing cases on pin 12
    pin12_case(8'h00, 8'h00, "R3");
    pin12_case(8'h01, 8'h00, "R5");
    pin12_case(8'h01, 8'h01, "R5");
    pin12_case(8'h01, 8'h02, "R4");
    pin12_case(8'h03, 8'h02, "R5");
    pin12_case(8'hFF, 8'h0A, "R5");
    pin12_case(8'hFF, 8'h08, "R5");
    pin12_case(8'hF7, 8'h08, "R5");

    // R4: aux bits with no direction stay off the pins
    pin12_case(8'h00, 8'h00, "R4");
    @(negedge clk);
    aux_a = '1; aux_b = '1;
    #1 check("R4 aux masked", pin_out, '0);
    // R2: direction write on core 2, aux then drives those pins
    wr_en[2] = 1'b1; wr_sel[2] = 1'b0; wr_data[2*NP +: NP] = 32'h0000_FF00;
    @(negedge clk);
    wr_en = '0;
    check("R2 dir write", pin_dir, 32'h0000_FF00);
    check("R4 aux via dir", pin_out, 32'h0000_FF00);
    idle_inputs();

    // R7: write and shutdown in the same cycle
    @(negedge clk);
    active[2] = 1'b0;
    wr_en[2] = 1'b1; wr_sel[2] = 1'b0; wr_data[2*NP +: NP] = 32'hFFFF_FFFF;
    #1 check("R6 immediate removal", pin_dir, '0);
    @(negedge clk);
    idle_inputs();
    active[2] = 1'b1;
    #1 check("R7 shutdown wins", pin_dir, '0);

    // R6: registers cleared after reactivation
    @(negedge clk);
    wr_en[5] = 1'b1; wr_sel[5] = 1'b1; wr_data[5*NP +: NP] = 32'h1234_5678;
    @(negedge clk);
    wr_en[5] = 1'b1; wr_sel[5] = 1'b0; wr_data[5*NP +: NP] = 32'hFFFF_0000;
    @(negedge clk);
    idle_inputs();
    check("R2 out write", pin_out, 32'h1234_0000);
    active[5] = 1'b0;
    @(negedge clk);
    active[5] = 1'b1;
    @(negedge clk);
    check("R6 cleared dir", pin_dir, '0);
    check("R6 cleared out", pin_out, '0);

    // random phase, checked every cycle against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      active = ($urandom_range(0, 9) == 0) ? 8'($urandom) : '1;
      wr_en = 8'($urandom); wr_sel = 8'($urandom);
      for (int c = 0; c < NC; c++) begin
        wr_data[c*NP +: NP] = $urandom & $urandom;
        aux_a[c*NP +: NP] = ($urandom_range(0, 3) == 0) ? $urandom : '0;
        aux_b[c*NP +: NP] = ($urandom_range(0, 3) == 0) ? $urandom : '0;
      end
      level = $urandom;
    end
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule